// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block sequences an integrating analog-to-digital conversion built around an external integrator and a zero-crossing comparator. On a start request it releases the integrator's clear and routes the unknown input to it for a fixed number of clock cycles. It then switches the integrator to the negative reference and counts, with the same counter restarted from zero, until the comparator reports that the integrator output has crossed zero. The count reached at that point is latched as the conversion result. The discharge slope is constant, so the result is proportional to the input.

The integrate window is 2^INT_BITS cycles. The result is INT_BITS+1 bits wide, which gives a de-integrate range twice the integrate window. If the comparator never falls before the counter reaches all ones, the conversion stops with the full-scale count and an overrange flag.

The result leaves the block as a held value qualified by a one-cycle done pulse. There is no back-pressure path. The value stays stable until the next conversion completes, so a consumer has a full conversion time to read it. The start input is a plain request that is accepted only while the block is idle.

Top module: `dual_slope_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the block is idle with int_clear_o=1, in_sel_o=0, done_o=0, result_o=0 and ovr_o=0.
- R2: A start_i high sampled while idle begins the integrate phase on the next cycle. For exactly 2^INT_BITS cycles, int_clear_o=0 and in_sel_o=0, where in_sel_o=0 selects the unknown input.
- R3: The de-integrate phase follows the integrate phase directly, with in_sel_o=1 (reference selected), int_clear_o=0 and the counter restarted at zero.
- R4: In the de-integrate phase, cmp_hi_i is sampled every cycle. The first sample that is low ends the phase, and result_o becomes the number of earlier de-integrate samples that were high.
- R5: done_o is high for exactly one cycle, starting at the edge that latches the result. That edge falls 2^INT_BITS + result_o + 1 cycles after the edge that accepted start_i.
- R6: If cmp_hi_i is still high when the count equals all ones (2^(INT_BITS+1)-1), the conversion ends with result_o all ones and ovr_o=1. A low sample at that same count gives all ones with ovr_o=0.
- R7: start_i is ignored in every cycle where the block is not idle, including the done cycle. It neither restarts nor extends the conversion, and it does not cause a second conversion.
- R8: After done_o the block returns to idle (int_clear_o=1, in_sel_o=0). result_o and ovr_o hold their values until the next done_o.
- R9: cmp_hi_i has no effect outside the de-integrate phase. A low level during the integrate phase neither ends nor shortens the conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, accepted only when idle |
| cmp_hi_i | input | 1 | Zero-crossing comparator, high while integrator output is not below zero |
| in_sel_o | output | 1 | Integrator source: 0 unknown input, 1 negative reference |
| int_clear_o | output | 1 | Holds the integrator at its starting level while high |
| result_o | output | INT_BITS+1 | Latched conversion count |
| ovr_o | output | 1 | Overrange flag for the latched result |
| done_o | output | 1 | One-cycle pulse when a new result is latched |

## Verification
The done pulse for a conversion is due 2^INT_BITS + result + 1 clock edges after the edge that accepted start. The bench model of the integrator and comparator advances on falling edges, so every comparator sample the block takes has a known value. The driver records the cycle number of the accepting edge with each expected item. The monitor samples on falling edges and checks the result, the overrange flag, the exact latency and the number of integrate and de-integrate cycles it saw. Idle state and held results are checked one cycle after done, and ignored start pulses are checked by watching for any unexpected done over a window longer than a conversion.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INTEG = 2'd1,
    PH_DEINT = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;
endpackage

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = &cnt_q;

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |-> !full_o)
    else $error("counter asked to wrap");
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int unsigned INT_BITS = 8,
  localparam int unsigned CW      = INT_BITS + 1,
  localparam int unsigned INT_LEN = 1 << INT_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmp_hi_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          full_i,
  output phase_e        phase_o,
  output logic          clr_o,
  output logic          inc_o,
  output logic          latch_o,
  output logic          ovr_o
);
  localparam logic [CW-1:0] INT_LAST = CW'(INT_LEN - 1);

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    latch_o = 1'b0;
    ovr_o   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_INTEG;
          clr_o   = 1'b1;
        end
      end
      PH_INTEG: begin
        if (cnt_i == INT_LAST) begin
          phase_d = PH_DEINT;
          clr_o   = 1'b1;
        end else begin
          inc_o = 1'b1;
        end
      end
      PH_DEINT: begin
        if (!cmp_hi_i) begin
          phase_d = PH_DONE;
          latch_o = 1'b1;
        end else if (full_i) begin
          phase_d = PH_DONE;
          latch_o = 1'b1;
          ovr_o   = 1'b1;
        end else begin
          inc_o = 1'b1;
        end
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE) |=> (phase_q == PH_IDLE))
    else $error("done phase lasted more than one cycle");

  // R2
  integ_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_INTEG) |-> (cnt_i <= INT_LAST))
    else $error("integrate phase overran its window");

  // R3
  deint_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DEINT && $past(phase_q) == PH_INTEG) |-> (cnt_i == '0))
    else $error("de-integrate count did not restart at zero");

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (phase_q != PH_INTEG) || ($past(phase_q) == PH_INTEG))
    else $error("integrate phase entered from a busy phase");
endmodule

// File: rtl/dsadc_result.sv
module dsadc_result #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_i,
  input  logic [CW-1:0] val_i,
  input  logic          ovr_i,
  output logic [CW-1:0] res_o,
  output logic          ovr_o
);
  logic [CW-1:0] res_q;
  logic          ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovr_q <= 1'b0;
    end else if (latch_i) begin
      res_q <= val_i;
      ovr_q <= ovr_i;
    end
  end

  assign res_o = res_q;
  assign ovr_o = ovr_q;

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> ($stable(res_q) && $stable(ovr_q)))
    else $error("result changed without a latch");

  // R6
  ovr_full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> (&res_q))
    else $error("overrange flagged with a count below full scale");
endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
  import dsadc_pkg::*;
#(
  parameter int unsigned INT_BITS = 8,
  localparam int unsigned CW      = INT_BITS + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmp_hi_i,
  output logic          in_sel_o,
  output logic          int_clear_o,
  output logic [CW-1:0] result_o,
  output logic          ovr_o,
  output logic          done_o
);
  phase_e        phase;
  logic          cnt_clr, cnt_inc, cnt_full, latch, ovr_hit;
  logic [CW-1:0] cnt;

  dsadc_seq #(.INT_BITS(INT_BITS)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cmp_hi_i(cmp_hi_i),
    .cnt_i   (cnt),
    .full_i  (cnt_full),
    .phase_o (phase),
    .clr_o   (cnt_clr),
    .inc_o   (cnt_inc),
    .latch_o (latch),
    .ovr_o   (ovr_hit)
  );

  dsadc_counter #(.CW(CW)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt),
    .full_o(cnt_full)
  );

  dsadc_result #(.CW(CW)) res_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .latch_i(latch),
    .val_i  (cnt),
    .ovr_i  (ovr_hit),
    .res_o  (result_o),
    .ovr_o  (ovr_o)
  );

  assign in_sel_o    = (phase == PH_DEINT);
  assign int_clear_o = (phase == PH_IDLE) || (phase == PH_DONE);
  assign done_o      = (phase == PH_DONE);

  // R8
  clear_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (int_clear_o && !in_sel_o && !done_o))
    else $error("block did not return to idle after done");
endmodule

// File: tb/dual_slope_ctrl_tb_top.sv
module dual_slope_ctrl_tb_top;
  localparam int unsigned NB     = 4;
  localparam int unsigned CW     = NB + 1;
  localparam int          ILEN   = 1 << NB;
  localparam int          FULL   = (1 << CW) - 1;
  localparam int          VREF   = ILEN;
  localparam int          WD_MAX = 20000;

  typedef struct {
    int vin;
    int res;
    bit ovr;
    int start_cyc;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cmp_hi = 1'b1;
  logic          in_sel, int_clear, ovr, done;
  logic [CW-1:0] result;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  int    vin_now = 0;
  bit    force_low = 1'b0;
  int    integ_v = 0;
  int    n_integ = 0;
  int    n_deint = 0;
  int    n_done = 0;
  bit    finished = 1'b0;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  dual_slope_ctrl #(.INT_BITS(NB)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cmp_hi_i   (cmp_hi),
    .in_sel_o   (in_sel),
    .int_clear_o(int_clear),
    .result_o   (result),
    .ovr_o      (ovr),
    .done_o     (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // cycle counter and watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_MAX) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WD_MAX);
      finish_run();
    end
  end

  // integrator and comparator model, advanced away from the active edge
  always @(negedge clk) begin
    if (int_clear)    integ_v = 0;
    else if (!in_sel) integ_v = integ_v + vin_now;
    else              integ_v = integ_v - VREF;
    if (force_low && !in_sel && !int_clear) cmp_hi = 1'b0;
    else                                     cmp_hi = (integ_v >= 0);
  end

  // monitor: compares each done against the oldest expected item
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        item_t it;
        n_done++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected done", 1, 0);
        end else begin
          it = exp_q.pop_front();
          chk(int'(result) == it.res, "R4", "result", int'(result), it.res);
          chk(ovr == it.ovr, "R6", "overrange flag", int'(ovr), int'(it.ovr));
          chk(cyc - it.start_cyc == ILEN + it.res + 1, "R5", "done latency",
              cyc - it.start_cyc, ILEN + it.res + 1);
          chk(n_integ == ILEN, "R2", "integrate cycles", n_integ, ILEN);
          chk(n_deint == it.res + 1, "R3", "de-integrate cycles", n_deint, it.res + 1);
        end
        n_integ = 0;
        n_deint = 0;
      end else begin
        if (!int_clear && !in_sel) n_integ++;
        if (in_sel)                n_deint++;
      end
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic convert(input int vin, input bit frc, input bit poke);
    item_t it;
    int    seen;
    @(negedge clk);
    vin_now   = vin;
    force_low = frc;
    it.vin = vin;
    it.res = (vin > FULL) ? FULL : vin;
    it.ovr = (vin > FULL);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    it.start_cyc = cyc;
    exp_q.push_back(it);
    if (poke) begin
      repeat (5) @(negedge clk);
      pulse_start();                    // R7: during integrate
      while (!in_sel) @(negedge clk);
      @(negedge clk);
      pulse_start();                    // R7: during de-integrate
    end
    while (!done) @(negedge clk);
    if (poke) start = 1'b1;             // R7: during the done cycle
    @(negedge clk);
    start = 1'b0;
    chk(int_clear && !in_sel && !done, "R8", "idle after done",
        {int_clear, in_sel, done}, 3'b100);
    chk(int'(result) == it.res, "R8", "result held", int'(result), it.res);
    if (poke) begin
      seen = n_done;
      repeat (ILEN + FULL + 8) @(negedge clk);
      chk(n_done == seen, "R7", "extra done after ignored starts", n_done - seen, 0);
      chk(int_clear && !in_sel, "R7", "still idle", {int_clear, in_sel}, 2'b10);
    end
    force_low = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(int_clear && !in_sel && !done && result == '0 && !ovr, "R1", "state in reset",
        {int_clear, in_sel, done, ovr}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(int_clear && !in_sel && !done, "R1", "idle after reset",
        {int_clear, in_sel, done}, 3'b100);
    chk(result == '0 && !ovr, "R1", "cleared result", int'(result), 0);

    convert(0, 1'b0, 1'b0);   // R4: zero input
    convert(1, 1'b0, 1'b0);
    convert(3, 1'b0, 1'b0);
    convert(16, 1'b0, 1'b0);
    convert(7, 1'b0, 1'b0);
    convert(FULL, 1'b0, 1'b0);      // R6: last in-range count
    convert(FULL + 1, 1'b0, 1'b0);  // R6: overrange
    convert(50, 1'b0, 1'b0);        // R6: far overrange
    convert(2, 1'b0, 1'b0);         // R8: flag clears on next result
    convert(5, 1'b1, 1'b0);         // R9: comparator low during integrate
    convert(9, 1'b0, 1'b1);         // R7: starts while busy
    convert(12, 1'b0, 1'b0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "outstanding expected items", exp_q.size(), 0);
    finish_run();
  end
endmodule